// File: doc/BRIEF.md
# Register-Write Command Stream Packer

This block turns a series of sequencer requests into a compact byte-coded command stream held in an on-chip byte buffer. The supported requests are a register write (address and data), setting a flag, waiting on a flag, and a delay. Register writes are shortened by remembering the last address and data put into the stream. The data part is left out when it has not changed. The upper 16 bits of either value are left out when they match the remembered upper half.

A producer offers one request at a time on a valid/ready handshake. An accepted request that produces bytes keeps the block busy while those bytes go into the buffer at one byte per clock. A finish request computes the padded stream length in 32-bit words and compares it with a capacity parameter. It reports either a ready flag or an out-of-space flag. A restart request starts a fresh stream. A consumer reads the buffer one 32-bit word at a time through a combinational read port.

Top module: `regseq_packer`

## Requirements
- R1: After reset, req_ready is 1, overflow, fin_ok and fin_nospace are 0, and every buffer word reads 0x7F7F7F7F.
- R2: A write whose data equals the remembered data emits no data command, so the stream holds only the address command. Both remembered values are all ones after reset and after restart.
- R3: A write whose data differs from the remembered data in bits [31:16] emits 0xE2 and then data bytes 0 to 3, least significant first.
- R4: A write whose data differs from the remembered data but matches it in bits [31:16] emits 0x42 and then data bytes 0 and 1, least significant first.
- R5: After any data command, a write emits 0xE0 and address bytes 0 to 3 when address bits [31:16] differ from the remembered address. Otherwise it emits 0x40 and address bytes 0 and 1. The accepted write then becomes the remembered address and data.
- R6: A flag-set request (flag number in req_flag, signed value in req_data) emits one byte. The byte is 0x80 + flag, plus 0x20 when the value is 0 or more, plus a further 0x20 when it is 1 or more, all modulo 256.
- R7: A wait request emits three bytes: 0x5F, then req_flag, then req_data[7:0].
- R8: A delay request takes req_data as nanoseconds and keeps the low 8 bits of the microsecond count nanoseconds/1000. It divides that count by 4 until it is at most 3, counting the steps as S. It emits one byte with S in bits [4:2] and the remaining count in bits [1:0].
- R9: An accepted request of n bytes drops req_ready for exactly n clocks after acceptance and writes one byte per clock. Finish, restart and rejected requests leave req_ready high.
- R10: A finish request sets word_count to (bytes + 4) / 4, truncated. It raises fin_ok when word_count is at most CAP_WORDS and fin_nospace otherwise, never both.
- R11: A request whose bytes would take the stream past BUF_BYTES is rejected whole. It writes no byte, changes no remembered value and sets overflow, which stays set until restart.
- R12: A restart request empties the stream, makes every word read 0x7F7F7F7F, sets the remembered address and data to all ones, and clears overflow, fin_ok and fin_nospace.
- R13: Read word w holds stream bytes 4w to 4w+3 with byte 4w in bits [7:0]. Any byte not yet written reads 0x7F.

Request codes on req_op: 0 write, 1 flag set, 2 wait, 3 delay, 4 finish, 5 restart. Codes 6 and 7 are accepted and do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken this clock if valid |
| req_op | input | 3 | Request code |
| req_addr | input | 32 | Register address for writes |
| req_data | input | 32 | Write data, flag value, wait value or nanoseconds |
| req_flag | input | 8 | Flag number for flag set and wait |
| rd_addr | input | 7 | Word index for readout |
| rd_word | output | 32 | Buffer word at rd_addr |
| word_count | output | 8 | Padded length in words from the last finish |
| fin_ok | output | 1 | Last finish fits the capacity |
| fin_nospace | output | 1 | Last finish exceeds the capacity |
| overflow | output | 1 | Sticky buffer overflow flag |

## Verification
The bench drives writes that exercise each data/address combination: data unchanged, low half changed, upper half changed, and the all-ones start value. A design that compared the wrong half or forgot to update its remembered values would put too many or too few bytes in the stream, and the byte-by-byte scoreboard would show the mismatch. Delay values either side of each division step and the 8-bit wrap show a wrong shift field. Flag values of -1, 0 and above 0 show a wrong sign treatment. The capacity is reached exactly, and the buffer is filled to exactly its last byte with a request of more than one byte rejected at that point. An off-by-one would accept a request it should refuse, or refuse one that fits, and the bench sees this in the busy cycles, the overflow flag and the final bytes.

// File: rtl/regseq_pkg.sv
package regseq_pkg;

  typedef enum logic [2:0] {
    OP_WRITE   = 3'd0,
    OP_SETF    = 3'd1,
    OP_WAIT    = 3'd2,
    OP_DELAY   = 3'd3,
    OP_FINISH  = 3'd4,
    OP_RESTART = 3'd5
  } op_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_EMIT = 1'b1
  } state_e;

  localparam logic [7:0] C_DATA_LONG  = 8'hE2;
  localparam logic [7:0] C_DATA_SHORT = 8'h42;
  localparam logic [7:0] C_ADDR_LONG  = 8'hE0;
  localparam logic [7:0] C_ADDR_SHORT = 8'h40;
  localparam logic [7:0] C_WAIT       = 8'h5F;
  localparam logic [7:0] C_SETF_BASE  = 8'h80;
  localparam logic [7:0] C_PAD        = 8'h7F;

  // flag set byte: base + flag, +0x20 for value >= 0, +0x20 more for >= 1
  function automatic logic [7:0] f_setf_byte(input logic [7:0] flag,
                                             input logic signed [31:0] val);
    logic [7:0] b;
    b = C_SETF_BASE + flag;
    if (val >= 0) b = b + 8'h20;
    if (val >= 1) b = b + 8'h20;
    return b;
  endfunction

  // delay byte: microseconds (low 8 bits), reduced by /4 steps
  function automatic logic [7:0] f_delay_byte(input logic [31:0] nsec);
    logic [31:0] q;
    logic [7:0]  u;
    logic [2:0]  sh;
    q  = nsec / 32'd1000;
    u  = q[7:0];
    sh = 3'd0;
    for (int i = 0; i < 4; i++) begin
      if (u[7:2] != 6'd0) begin
        u  = u >> 2;
        sh = sh + 3'd1;
      end
    end
    return {3'b000, sh, u[1:0]};
  endfunction

  function automatic int f_word_count(input int bytes);
    return (bytes + 4) / 4;
  endfunction

endpackage

// File: rtl/regseq_encoder.sv
module regseq_encoder
  import regseq_pkg::*;
#(
  parameter int MAX_CMD = 10,
  parameter int LEN_W   = $clog2(MAX_CMD + 1)
) (
  input  logic [2:0]                 op,
  input  logic [31:0]                addr,
  input  logic [31:0]                data,
  input  logic [7:0]                 flag,
  input  logic [31:0]                rem_addr,
  input  logic [31:0]                rem_data,
  output logic [MAX_CMD-1:0][7:0]    cmd_bytes,
  output logic [LEN_W-1:0]           cmd_len,
  output logic                       data_skip,
  output logic                       data_long,
  output logic                       addr_long
);

  assign data_skip = (data == rem_data);
  assign data_long = (data[31:16] != rem_data[31:16]);
  assign addr_long = (addr[31:16] != rem_addr[31:16]);

  always_comb begin
    int k;
    cmd_bytes = '0;
    k = 0;
    case (op)
      OP_WRITE: begin
        if (!data_skip) begin
          if (data_long) begin
            cmd_bytes[0] = C_DATA_LONG;
            for (int j = 0; j < 4; j++) cmd_bytes[1+j] = data[8*j +: 8];
            k = 5;
          end else begin
            cmd_bytes[0] = C_DATA_SHORT;
            cmd_bytes[1] = data[7:0];
            cmd_bytes[2] = data[15:8];
            k = 3;
          end
        end
        if (addr_long) begin
          cmd_bytes[k] = C_ADDR_LONG;
          for (int j = 0; j < 4; j++) cmd_bytes[k+1+j] = addr[8*j +: 8];
          k = k + 5;
        end else begin
          cmd_bytes[k]   = C_ADDR_SHORT;
          cmd_bytes[k+1] = addr[7:0];
          cmd_bytes[k+2] = addr[15:8];
          k = k + 3;
        end
      end
      OP_SETF: begin
        cmd_bytes[0] = f_setf_byte(flag, data);
        k = 1;
      end
      OP_WAIT: begin
        cmd_bytes[0] = C_WAIT;
        cmd_bytes[1] = flag;
        cmd_bytes[2] = data[7:0];
        k = 3;
      end
      OP_DELAY: begin
        cmd_bytes[0] = f_delay_byte(data);
        k = 1;
      end
      default: k = 0;
    endcase
    cmd_len = LEN_W'(k);
  end

  // R2 guard: an unchanged write starts with the address command
  always_comb begin
    if (op == OP_WRITE && data_skip)
      a_skip_r2: assert (cmd_bytes[0] == C_ADDR_LONG || cmd_bytes[0] == C_ADDR_SHORT);
  end

  // R3/R4 guard: a changed write starts with a data command
  always_comb begin
    if (op == OP_WRITE && !data_skip)
      a_data_first_r3: assert (cmd_bytes[0] == C_DATA_LONG || cmd_bytes[0] == C_DATA_SHORT);
  end

endmodule

// File: rtl/regseq_store.sv
module regseq_store
  import regseq_pkg::*;
#(
  parameter int BUF_BYTES = 512,
  parameter int ADDR_W    = $clog2(BUF_BYTES),
  parameter int CNT_W     = $clog2(BUF_BYTES + 1),
  parameter int WADDR_W   = ADDR_W - 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               wr_en,
  input  logic [7:0]         wr_byte,
  input  logic [WADDR_W-1:0] rd_addr,
  output logic [31:0]        rd_word,
  output logic [CNT_W-1:0]   cnt
);

  logic [7:0] mem [BUF_BYTES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[cnt[ADDR_W-1:0]] <= wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (wr_en)  cnt <= cnt + CNT_W'(1);
  end

  // unwritten bytes read as pad value
  generate
    for (genvar k = 0; k < 4; k++) begin : g_lane
      logic [ADDR_W-1:0] idx;
      logic              live;
      assign idx  = {rd_addr, 2'(k)};
      assign live = (CNT_W'(idx) < cnt);
      assign rd_word[8*k +: 8] = live ? mem[idx] : C_PAD;
    end
  endgenerate

  p_write_in_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (cnt < CNT_W'(BUF_BYTES)));

  p_one_byte_per_clock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clear) |=> (cnt == $past(cnt) + CNT_W'(1)));

  p_clear_empties_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));

endmodule

// File: rtl/regseq_packer.sv
module regseq_packer
  import regseq_pkg::*;
#(
  parameter int BUF_BYTES = 512,
  parameter int CAP_WORDS = 128,
  parameter int MAX_CMD   = 10,
  localparam int ADDR_W   = $clog2(BUF_BYTES),
  localparam int CNT_W    = $clog2(BUF_BYTES + 1),
  localparam int WADDR_W  = ADDR_W - 2,
  localparam int WC_W     = $clog2(BUF_BYTES / 4 + 2),
  localparam int LEN_W    = $clog2(MAX_CMD + 1),
  localparam int IDX_W    = $clog2(MAX_CMD)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [2:0]         req_op,
  input  logic [31:0]        req_addr,
  input  logic [31:0]        req_data,
  input  logic [7:0]         req_flag,
  input  logic [WADDR_W-1:0] rd_addr,
  output logic [31:0]        rd_word,
  output logic [WC_W-1:0]    word_count,
  output logic               fin_ok,
  output logic               fin_nospace,
  output logic               overflow
);

  state_e                  state;
  logic [31:0]             rem_addr, rem_data;
  logic [MAX_CMD-1:0][7:0] stage;
  logic [LEN_W-1:0]        st_len;
  logic [IDX_W-1:0]        st_idx;

  logic [MAX_CMD-1:0][7:0] enc_bytes;
  logic [LEN_W-1:0]        enc_len;
  logic                    enc_skip, enc_dlong, enc_along;
  logic [CNT_W-1:0]        cnt;

  // named events for checks
  logic accept, emits, fits, take_evt, reject_evt, fin_evt, restart_evt, emit_last;
  int   fin_words;

  assign req_ready   = (state == S_IDLE);
  assign accept      = req_valid && req_ready;
  assign emits       = (req_op == OP_WRITE) || (req_op == OP_SETF) ||
                       (req_op == OP_WAIT)  || (req_op == OP_DELAY);
  assign fits        = ((CNT_W+1)'(cnt) + (CNT_W+1)'(enc_len)) <= (CNT_W+1)'(BUF_BYTES);
  assign take_evt    = accept && emits && fits;
  assign reject_evt  = accept && emits && !fits;
  assign fin_evt     = accept && (req_op == OP_FINISH);
  assign restart_evt = accept && (req_op == OP_RESTART);
  assign emit_last   = (state == S_EMIT) && (LEN_W'(st_idx) == st_len - LEN_W'(1));
  assign fin_words   = f_word_count(int'(cnt));

  regseq_encoder #(.MAX_CMD(MAX_CMD), .LEN_W(LEN_W)) i_enc (
    .op        (req_op),
    .addr      (req_addr),
    .data      (req_data),
    .flag      (req_flag),
    .rem_addr  (rem_addr),
    .rem_data  (rem_data),
    .cmd_bytes (enc_bytes),
    .cmd_len   (enc_len),
    .data_skip (enc_skip),
    .data_long (enc_dlong),
    .addr_long (enc_along)
  );

  regseq_store #(.BUF_BYTES(BUF_BYTES)) i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (restart_evt),
    .wr_en   (state == S_EMIT),
    .wr_byte (stage[st_idx]),
    .rd_addr (rd_addr),
    .rd_word (rd_word),
    .cnt     (cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      rem_addr    <= '1;
      rem_data    <= '1;
      stage       <= '0;
      st_len      <= '0;
      st_idx      <= '0;
      overflow    <= 1'b0;
      fin_ok      <= 1'b0;
      fin_nospace <= 1'b0;
      word_count  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (take_evt) begin
            stage       <= enc_bytes;
            st_len      <= enc_len;
            st_idx      <= '0;
            state       <= S_EMIT;
            fin_ok      <= 1'b0;
            fin_nospace <= 1'b0;
            if (req_op == OP_WRITE) begin
              rem_addr <= req_addr;
              rem_data <= req_data;
            end
          end else if (reject_evt) begin
            overflow    <= 1'b1;
            fin_ok      <= 1'b0;
            fin_nospace <= 1'b0;
          end else if (fin_evt) begin
            word_count  <= WC_W'(fin_words);
            fin_ok      <= (fin_words <= CAP_WORDS);
            fin_nospace <= (fin_words >  CAP_WORDS);
          end else if (restart_evt) begin
            rem_addr    <= '1;
            rem_data    <= '1;
            overflow    <= 1'b0;
            fin_ok      <= 1'b0;
            fin_nospace <= 1'b0;
            word_count  <= '0;
          end
        end
        S_EMIT: begin
          st_idx <= st_idx + IDX_W'(1);
          if (emit_last) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_busy_after_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_evt |=> !req_ready);

  p_idle_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    emit_last |=> req_ready);

  p_reject_keeps_cnt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> ($stable(cnt) && req_ready && overflow));

  p_overflow_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !restart_evt) |=> overflow);

  p_fin_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fin_ok && fin_nospace));

  p_restart_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    restart_evt |=> (!overflow && !fin_ok && !fin_nospace && rem_addr == '1 && rem_data == '1));

  p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(BUF_BYTES));

endmodule

// File: tb/test_regseq_packer.sv
module test_regseq_packer;
  localparam int CLK_PERIOD = 10;
  localparam int CAP = 8;
  localparam int BUFB = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [31:0] req_addr = '0, req_data = '0;
  logic [7:0]  req_flag = '0;
  logic [6:0]  rd_addr = '0;
  logic [31:0] rd_word;
  logic [7:0]  word_count;
  logic        fin_ok, fin_nospace, overflow;

  regseq_packer #(.BUF_BYTES(BUFB), .CAP_WORDS(CAP)) i_regseq_packer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_flag(req_flag),
    .rd_addr(rd_addr), .rd_word(rd_word), .word_count(word_count),
    .fin_ok(fin_ok), .fin_nospace(fin_nospace), .overflow(overflow));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // model state
  logic [7:0]  expq[$];
  int          model_cnt = 0, mon_pos = 0;
  logic [31:0] m_addr = '1, m_data = '1;
  bit          m_ovf = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd_byte(input int p, output logic [7:0] b);
    rd_addr = 7'(p / 4);
    #1;
    b = rd_word[8*(p%4) +: 8];
  endtask

  // monitor: pop expected bytes and compare with buffer readout
  task automatic drain(input string req);
    logic [7:0] e, a;
    while (expq.size() > 0) begin
      e = expq.pop_front();
      rd_byte(mon_pos, a);
      chk(a == e, req, a, e);
      mon_pos++;
    end
    if (mon_pos < BUFB) begin
      rd_byte(mon_pos, a);
      chk(a == 8'h7F, {req, "/R13 pad"}, a, 8'h7F);
    end
  endtask

  function automatic logic [7:0] m_setf(input logic [7:0] fl, input int v);
    int add;
    add = (v < 0) ? 0 : ((v == 0) ? 32 : 64);
    return 8'((128 + int'(fl) + add) % 256);
  endfunction

  function automatic logic [7:0] m_delay(input longint ns);
    int us, s;
    us = int'((ns / 1000) % 256);
    s = 0;
    while (us > 3) begin us = us / 4; s++; end
    return 8'(s * 4 + us);
  endfunction

  // driver: build expected bytes, push to scoreboard, drive, check busy time
  task automatic req(input int op, input logic [31:0] a, input logic [31:0] d,
                     input logic [7:0] fl, input string tag);
    logic [7:0] tmp[$];
    int busy;
    bit fit;
    tmp = {};
    if (op == 0) begin
      if (d != m_data) begin
        if (d[31:16] != m_data[31:16]) tmp = {8'hE2, d[7:0], d[15:8], d[23:16], d[31:24]};
        else tmp = {8'h42, d[7:0], d[15:8]};
      end
      if (a[31:16] != m_addr[31:16]) tmp = {tmp, 8'hE0, a[7:0], a[15:8], a[23:16], a[31:24]};
      else tmp = {tmp, 8'h40, a[7:0], a[15:8]};
    end else if (op == 1) tmp = {m_setf(fl, int'($signed(d)))};
    else if (op == 2) tmp = {8'h5F, fl, d[7:0]};
    else if (op == 3) tmp = {m_delay(longint'(d))};
    fit = (model_cnt + tmp.size()) <= BUFB;
    if (tmp.size() > 0 && !fit) begin
      m_ovf = 1;
      tmp = {};
    end else if (tmp.size() > 0) begin
      foreach (tmp[i]) expq.push_back(tmp[i]);
      model_cnt += tmp.size();
      if (op == 0) begin m_addr = a; m_data = d; end
    end
    if (op == 5) begin
      model_cnt = 0; mon_pos = 0; m_addr = '1; m_data = '1; m_ovf = 0; expq = {};
    end
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = 3'(op); req_addr = a; req_data = d; req_flag = fl; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0;
    while (!req_ready) begin busy++; @(negedge clk); end
    chk(busy == tmp.size(), {tag, "/R9 busy"}, busy, tmp.size());
    chk(overflow == m_ovf, {tag, "/R11 overflow"}, overflow, m_ovf);
  endtask

  task automatic finish_chk(input string tag);
    int wc;
    req(4, 0, 0, 0, tag);
    wc = (model_cnt + 4) / 4;
    chk(word_count == wc, {tag, "/R10 words"}, word_count, wc);
    chk(fin_ok == (wc <= CAP), {tag, "/R10 ok"}, fin_ok, wc <= CAP);
    chk(fin_nospace == (wc > CAP), {tag, "/R10 nospace"}, fin_nospace, wc > CAP);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1, "R1 ready", req_ready, 1);
    chk(overflow == 0 && fin_ok == 0 && fin_nospace == 0, "R1 flags",
        {overflow, fin_ok, fin_nospace}, 0);
    rd_addr = 0;   #1; chk(rd_word == 32'h7F7F7F7F, "R1 word0", rd_word, 32'h7F7F7F7F);
    rd_addr = 127; #1; chk(rd_word == 32'h7F7F7F7F, "R1 word127", rd_word, 32'h7F7F7F7F);

    // R2/R5: data equals all-ones start value, address upper differs
    req(0, 32'h12345678, 32'hFFFFFFFF, 0, "R2 R5 first write");
    // R4 + short address
    req(0, 32'h1234AAAA, 32'hFFFF0001, 0, "R4 R5 short");
    drain("R4 R13 stream");
    finish_chk("R10 small");
    // R3 long data, long address
    req(0, 32'h00000010, 32'hDEADBEEF, 0, "R3 R5 long");
    // R2 unchanged data, short address
    req(0, 32'h00000020, 32'hDEADBEEF, 0, "R2 skip");
    drain("R3 R2 stream");
    // R6 flag set
    req(1, 0, 32'hFFFFFFFF, 8'd3, "R6 neg");
    req(1, 0, 32'd0, 8'd3, "R6 zero");
    req(1, 0, 32'd5, 8'd3, "R6 pos");
    req(1, 0, 32'd1, 8'hF0, "R6 wrap");
    // R7 wait
    req(2, 0, 32'h00000001, 8'd7, "R7 wait");
    // R8 delays
    req(3, 0, 32'd999, 0, "R8 zero");
    req(3, 0, 32'd2500, 0, "R8 two");
    req(3, 0, 32'd5000, 0, "R8 five");
    req(3, 0, 32'd100000, 0, "R8 hundred");
    req(3, 0, 32'd255000, 0, "R8 max");
    req(3, 0, 32'd300000, 0, "R8 mod256");
    drain("R6 R7 R8 stream");
    finish_chk("R10 over");

    // R12 restart then exact capacity boundary
    req(5, 0, 0, 0, "R12 restart");
    chk(fin_ok == 0 && fin_nospace == 0, "R12 flags", {fin_ok, fin_nospace}, 0);
    rd_addr = 0; #1; chk(rd_word == 32'h7F7F7F7F, "R12 empty", rd_word, 32'h7F7F7F7F);
    req(0, 32'h00000005, 32'hFFFFFFFF, 0, "R12 R2 remembered ones");
    drain("R12 stream");
    for (int i = 0; i < 23; i++) req(3, 0, 32'd4000, 0, "R10 fill");
    finish_chk("R10 at cap");
    for (int i = 0; i < 4; i++) req(3, 0, 32'd4000, 0, "R10 fill2");
    finish_chk("R10 past cap");
    drain("R10 stream");

    // R11 overflow at buffer end
    req(5, 0, 0, 0, "R12 restart2");
    for (int i = 0; i < BUFB - 1; i++) req(3, 0, 32'd1000 * (i % 200), 0, "R11 fill");
    req(2, 0, 32'h11, 8'h22, "R11 reject wait");
    req(1, 0, 32'd0, 8'd1, "R11 exact fit");
    req(3, 0, 32'd1000, 0, "R11 reject full");
    req(0, 32'h1, 32'h2, 0, "R11 reject write");
    drain("R11 stream");
    rd_byte(BUFB - 1, b);
    chk(b == 8'hA1, "R11 last byte", b, 8'hA1);
    // rejected write left remembered values: R5 after restart not tested; check data skip
    req(5, 0, 0, 0, "R12 restart3");
    chk(overflow == 0, "R12 ovf clear", overflow, 0);
    req(0, 32'hABCD0001, 32'hFFFFFFFF, 0, "R12 R2 after overflow");
    drain("R12 stream2");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule